// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block keeps an asynchronous DRAM alive. After reset it holds the row strobe high for a long power-up pause. It then runs a wake-up burst of refresh cycles before it declares the memory ready. From then on it spreads CAS-before-RAS refresh cycles evenly in time, so that every row is refreshed within the retention period. The row counter inside the DRAM supplies the row, so the block never drives an address, a write enable, an output enable or data.

The block shares the strobe pins with the access controller through a request/grant pair. It raises `bus_req` whenever refresh work is pending. It starts a refresh cycle only after it has seen `bus_gnt` high, and it keeps `bus_req` high until that cycle, including its precharge, is over. The controller is expected to keep the grant while the request stays high, and to select this block's strobes while it grants. If the grant is withheld, expired intervals build up in an owed counter, and the block later pays them back in back-to-back refresh cycles. If the owed counter reaches its ceiling, the retention budget may have been broken. In that case a sticky error flag is set, ready drops, and the full wake-up burst runs again.

The control machine has three states. `ST_PAUSE` is the state after reset. It moves to `ST_WAKE` when the pause counter expires. `ST_WAKE` moves to `ST_RUN` once the burst count reaches zero and no cycle is in flight. `ST_RUN` moves back to `ST_WAKE` when the owed count hits its ceiling. The strobe machine steps through six states: `SQ_IDLE` on start to `SQ_GAP` (both strobes high), then `SQ_CSR` (CAS low), then `SQ_CHR` (RAS and CAS low), then `SQ_RASLO` (RAS low only), then `SQ_PRE` (both high). It returns to `SQ_IDLE` with a done pulse. Each step leaves when its length counter reaches zero.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is asserted and just after it, `ras_n`, `lcas_n` and `ucas_n` are 1, and `bus_req`, `ready`, `owed_cnt` and `err_sticky` are 0.
- R2: After reset is released, `bus_req` stays low and no strobe moves for `PAUSE_CYC` clock edges. `bus_req` is first high in the cycle after the `PAUSE_CYC`-th edge.
- R3: The first wake-up burst has exactly `WAKE_CNT` refresh cycles (counted as falling edges of `ras_n`). `ready` rises only after the last of them has finished, with `ras_n` high.
- R4: In every refresh cycle, each enabled CAS strobe (`CAS_MASK` bit 0 drives `lcas_n`, bit 1 drives `ucas_n`; default both) is low for exactly `CSR_CYC` cycles before `ras_n` falls. It stays low for exactly `CHR_CYC` cycles with `ras_n` low and then rises while `ras_n` is still low. A CAS strobe never falls while `ras_n` is low.
- R5: `ras_n` stays low for exactly `RAS_CYC` cycles in each refresh cycle.
- R6: `ras_n` stays high for at least `PRE_CYC` cycles between refresh cycles. A CAS strobe stays high for at least `RPC_CYC` cycles before it falls.
- R7: From the end of the pause, the refresh interval timer expires every `INTERVAL_CYC` cycles. In `ST_RUN`, each expiry raises `owed_cnt` by one unless a refresh completes in the same cycle.
- R8: A refresh cycle begins only in the cycle after `bus_gnt` was sampled high with work pending. With the grant withheld, no refresh is started. `bus_req` is high during every refresh cycle and falls once nothing is owed and the strobe machine is idle.
- R9: With a backlog of k owed refreshes and the grant present, exactly k refresh cycles are issued back to back, with falling edges of `ras_n` spaced `RPC_CYC+CSR_CYC+RAS_CYC+PRE_CYC+1` cycles apart. `owed_cnt` then returns to 0.
- R10: When `owed_cnt` reaches `OWED_MAX`, in the next cycle `err_sticky` is set, `ready` is 0 and `owed_cnt` is 0. A new burst of `WAKE_CNT` refresh cycles must then finish before `ready` returns.
- R11: Once set, `err_sticky` stays 1 until reset.
- R12: In `ST_RUN` with the grant always present, exactly one refresh cycle is issued per refresh interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_gnt | input | 1 | Grant of the strobe bus from the access controller |
| bus_req | output | 1 | Request for the strobe bus |
| ras_n | output | 1 | Row strobe, active low |
| lcas_n | output | 1 | Lower-byte column strobe, active low |
| ucas_n | output | 1 | Upper-byte column strobe, active low |
| ready | output | 1 | Memory initialised and refresh in steady state |
| owed_cnt | output | $clog2(OWED_MAX+1) | Number of expired intervals not yet refreshed |
| err_sticky | output | 1 | Owed count reached its ceiling since reset |

## Verification
On every cycle, the assertions check the strobe ordering and pulse widths: the CAS lead before RAS, the CAS hold count, the RAS low width and the precharge gap. They also check that a cycle starts only after a grant, that the request covers a busy sequencer, that the strobes are quiet during the pause, that ready drops after saturation, and that the error flag stays set. Some behaviours only the bench scenarios can show. These are the exact pause length, the number of cycles in a wake-up burst, the spacing of interval expiries, the size and spacing of a backlog payback, and the one-refresh-per-interval rate in steady state.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;

    typedef enum logic [1:0] {
        ST_PAUSE,
        ST_WAKE,
        ST_RUN
    } ctl_state_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_GAP,
        SQ_CSR,
        SQ_CHR,
        SQ_RASLO,
        SQ_PRE
    } seq_state_e;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
    } strobe_t;

endpackage

// File: rtl/rfsh_tick_counter.sv
module rfsh_tick_counter #(
    parameter int LIMIT = 3120
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

    logic [CW-1:0] cnt_q;

    assign tick = en && (cnt_q == CW'(LIMIT - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!en) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    generate
        if (LIMIT > 1) begin : g_spacing
            // R7: an expiry is never followed at once by another
            a_r7_tick_spacing : assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/rfsh_owed_counter.sv
module rfsh_owed_counter #(
    parameter int MAX = 8,
    parameter int W   = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    input  logic         dec,
    output logic [W-1:0] owed,
    output logic         sat
);
    logic [W-1:0] owed_q;

    assign owed = owed_q;
    assign sat  = (owed_q == W'(MAX));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            owed_q <= '0;
        end else if (clr) begin
            owed_q <= '0;
        end else if (inc && !dec && !sat) begin
            owed_q <= owed_q + W'(1);
        end else if (dec && !inc && (owed_q != '0)) begin
            owed_q <= owed_q - W'(1);
        end
    end

    // R7: the backlog grows by at most one per cycle
    a_r7_owed_step : assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ({1'b0, owed_q} <= ({1'b0, $past(owed_q)} + (W+1)'(1))));

    // R10: a saturated count is never exceeded
    a_r10_sat_hold : assert property (@(posedge clk) disable iff (!rst_n)
        (sat && !clr && !dec) |=> sat);

endmodule

// File: rtl/rfsh_strobe_seq.sv
module rfsh_strobe_seq
    import dram_rfsh_pkg::*;
#(
    parameter int RPC_CYC = 1,
    parameter int CSR_CYC = 1,
    parameter int CHR_CYC = 2,
    parameter int RAS_CYC = 12,
    parameter int PRE_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done,
    output logic ras_n,
    output logic cas_n
);
    localparam int L_RLO   = RAS_CYC - CHR_CYC;
    localparam int MAX_A   = (RPC_CYC > CSR_CYC) ? RPC_CYC : CSR_CYC;
    localparam int MAX_B   = (CHR_CYC > L_RLO) ? CHR_CYC : L_RLO;
    localparam int MAX_C   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MAX_LEN = (MAX_C > PRE_CYC) ? MAX_C : PRE_CYC;
    localparam int CW      = $clog2(MAX_LEN + 1);
    localparam int MW      = $clog2(RAS_CYC + PRE_CYC + CSR_CYC + 4) + 1;

    seq_state_e    st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    strobe_t       strb;

    // state and length counter register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= SQ_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // next state
    always_comb begin
        st_d  = st_q;
        cnt_d = (cnt_q != '0) ? cnt_q - CW'(1) : cnt_q;
        done  = 1'b0;
        unique case (st_q)
            SQ_IDLE: begin
                cnt_d = cnt_q;
                if (start) begin
                    st_d  = SQ_GAP;
                    cnt_d = CW'(RPC_CYC - 1);
                end
            end
            SQ_GAP: begin
                if (cnt_q == '0) begin
                    st_d  = SQ_CSR;
                    cnt_d = CW'(CSR_CYC - 1);
                end
            end
            SQ_CSR: begin
                if (cnt_q == '0) begin
                    st_d  = SQ_CHR;
                    cnt_d = CW'(CHR_CYC - 1);
                end
            end
            SQ_CHR: begin
                if (cnt_q == '0) begin
                    st_d  = SQ_RASLO;
                    cnt_d = CW'(L_RLO - 1);
                end
            end
            SQ_RASLO: begin
                if (cnt_q == '0) begin
                    st_d  = SQ_PRE;
                    cnt_d = CW'(PRE_CYC - 1);
                end
            end
            SQ_PRE: begin
                if (cnt_q == '0) begin
                    st_d = SQ_IDLE;
                    done = 1'b1;
                end
            end
            default: begin
                st_d  = SQ_IDLE;
                cnt_d = '0;
            end
        endcase
    end

    // strobe outputs decoded from state
    always_comb begin
        unique case (st_q)
            SQ_CSR:   strb = '{ras_n: 1'b1, cas_n: 1'b0};
            SQ_CHR:   strb = '{ras_n: 1'b0, cas_n: 1'b0};
            SQ_RASLO: strb = '{ras_n: 1'b0, cas_n: 1'b1};
            default:  strb = '{ras_n: 1'b1, cas_n: 1'b1};
        endcase
    end

    assign ras_n = strb.ras_n;
    assign cas_n = strb.cas_n;
    assign busy  = (st_q != SQ_IDLE);

    // run-length monitors used only by the assertions below
    logic [MW-1:0] ras_lo_run, ras_hi_run, cas_lead_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ras_lo_run   <= '0;
            ras_hi_run   <= '1;
            cas_lead_run <= '0;
        end else begin
            ras_lo_run   <= ras_n ? '0 : ((ras_lo_run == '1) ? ras_lo_run : ras_lo_run + MW'(1));
            ras_hi_run   <= !ras_n ? '0 : ((ras_hi_run == '1) ? ras_hi_run : ras_hi_run + MW'(1));
            cas_lead_run <= (cas_n || !ras_n) ? '0 :
                            ((cas_lead_run == '1) ? cas_lead_run : cas_lead_run + MW'(1));
        end
    end

    // R4: CAS is already low when RAS falls, for exactly the lead time
    a_r4_cas_lead : assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (cas_lead_run == MW'(CSR_CYC)));

    // R4: CAS never falls while RAS is low
    a_r4_no_cas_fall_in_ras : assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_n) |-> ras_n);

    // R5: RAS low width
    a_r5_ras_width : assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> (ras_lo_run == MW'(RAS_CYC)));

    // R6: precharge before the next RAS fall
    a_r6_precharge : assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (ras_hi_run >= MW'(PRE_CYC)));

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
    import dram_rfsh_pkg::*;
#(
    parameter int       PAUSE_CYC    = 40000,
    parameter int       INTERVAL_CYC = 3120,
    parameter int       WAKE_CNT     = 8,
    parameter int       OWED_MAX     = 8,
    parameter int       RPC_CYC      = 1,
    parameter int       CSR_CYC      = 1,
    parameter int       CHR_CYC      = 2,
    parameter int       RAS_CYC      = 12,
    parameter int       PRE_CYC      = 8,
    parameter bit [1:0] CAS_MASK     = 2'b11,
    localparam int      OWED_W       = $clog2(OWED_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_gnt,
    output logic              bus_req,
    output logic              ras_n,
    output logic              lcas_n,
    output logic              ucas_n,
    output logic              ready,
    output logic [OWED_W-1:0] owed_cnt,
    output logic              err_sticky
);
    localparam int WAKE_W = $clog2(WAKE_CNT + 1);

    ctl_state_e        st_q, st_d;
    logic [WAKE_W-1:0] wake_q, wake_d;
    logic              err_q;

    logic pause_tick, ivl_tick;
    logic owed_clr, owed_dec, owed_sat;
    logic seq_start, seq_busy, seq_done, seq_ras_n, seq_cas_n;
    logic pending;
    logic [1:0] cas_lane;

    rfsh_tick_counter #(.LIMIT(PAUSE_CYC)) u_pause (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (st_q == ST_PAUSE),
        .tick (pause_tick)
    );

    rfsh_tick_counter #(.LIMIT(INTERVAL_CYC)) u_ivl (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (st_q != ST_PAUSE),
        .tick (ivl_tick)
    );

    rfsh_owed_counter #(.MAX(OWED_MAX), .W(OWED_W)) u_owed (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (owed_clr),
        .inc  (ivl_tick),
        .dec  (owed_dec),
        .owed (owed_cnt),
        .sat  (owed_sat)
    );

    rfsh_strobe_seq #(
        .RPC_CYC(RPC_CYC),
        .CSR_CYC(CSR_CYC),
        .CHR_CYC(CHR_CYC),
        .RAS_CYC(RAS_CYC),
        .PRE_CYC(PRE_CYC)
    ) u_seq (
        .clk  (clk),
        .rst_n(rst_n),
        .start(seq_start),
        .busy (seq_busy),
        .done (seq_done),
        .ras_n(seq_ras_n),
        .cas_n(seq_cas_n)
    );

    // work pending and bus handshake
    always_comb begin
        unique case (st_q)
            ST_WAKE: pending = (wake_q != '0);
            ST_RUN:  pending = (owed_cnt != '0) && !owed_sat;
            default: pending = 1'b0;
        endcase
    end

    assign seq_start = pending && !seq_busy && bus_gnt;
    assign bus_req   = pending || seq_busy;
    assign owed_clr  = (st_q != ST_RUN) || owed_sat;
    assign owed_dec  = seq_done && (st_q == ST_RUN);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_PAUSE;
            wake_q <= '0;
            err_q  <= 1'b0;
        end else begin
            st_q   <= st_d;
            wake_q <= wake_d;
            err_q  <= err_q || (owed_sat && (st_q == ST_RUN));
        end
    end

    // next state and burst count
    always_comb begin
        st_d   = st_q;
        wake_d = wake_q;
        unique case (st_q)
            ST_PAUSE: begin
                if (pause_tick) begin
                    st_d   = ST_WAKE;
                    wake_d = WAKE_W'(WAKE_CNT);
                end
            end
            ST_WAKE: begin
                if (seq_done && (wake_q != '0)) begin
                    wake_d = wake_q - WAKE_W'(1);
                end
                if ((wake_q == '0) && !seq_busy) begin
                    st_d = ST_RUN;
                end
            end
            ST_RUN: begin
                if (owed_sat) begin
                    st_d   = ST_WAKE;
                    wake_d = WAKE_W'(WAKE_CNT);
                end
            end
            default: begin
                st_d   = ST_PAUSE;
                wake_d = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        ready      = (st_q == ST_RUN);
        err_sticky = err_q;
        ras_n      = seq_ras_n;
    end

    generate
        for (genvar i = 0; i < 2; i++) begin : g_cas
            if (CAS_MASK[i]) begin : g_on
                assign cas_lane[i] = seq_cas_n;
            end else begin : g_off
                assign cas_lane[i] = 1'b1;
            end
        end
    endgenerate

    assign lcas_n = cas_lane[0];
    assign ucas_n = cas_lane[1];

    // R2: strobes and request quiet during the pause
    a_r2_quiet_pause : assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_PAUSE) |-> (ras_n && lcas_n && ucas_n && !bus_req));

    // R3: ready rises only with the strobe machine idle
    a_r3_ready_idle : assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> (!seq_busy && ras_n));

    // R8: a cycle starts only after a grant
    a_r8_start_gnt : assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_busy) |-> $past(bus_gnt));

    // R8: request covers the whole cycle
    a_r8_req_hold : assert property (@(posedge clk) disable iff (!rst_n)
        seq_busy |-> bus_req);

    // R10: saturation drops ready next cycle
    a_r10_sat_drop : assert property (@(posedge clk) disable iff (!rst_n)
        (owed_cnt == OWED_W'(OWED_MAX)) |=> (!ready && err_sticky));

    // R11: error flag is sticky
    a_r11_err_sticky : assert property (@(posedge clk) disable iff (!rst_n)
        err_sticky |=> err_sticky);

endmodule

// File: tb/dram_refresh_seq_tb.sv
`timescale 1ns/1ps
module dram_refresh_seq_tb;
    localparam int PAUSE    = 300;
    localparam int INTERVAL = 400;
    localparam int WAKE     = 8;
    localparam int OMAX     = 8;
    localparam int RPC      = 1;
    localparam int CSR      = 1;
    localparam int CHR      = 2;
    localparam int RASW     = 12;
    localparam int PRE      = 8;
    localparam int OW       = $clog2(OMAX + 1);

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n, bus_gnt;
    logic bus_req, ras_n, lcas_n, ucas_n, ready, err_sticky;
    logic [OW-1:0] owed_cnt;

    dram_refresh_seq #(
        .PAUSE_CYC(PAUSE), .INTERVAL_CYC(INTERVAL), .WAKE_CNT(WAKE), .OWED_MAX(OMAX),
        .RPC_CYC(RPC), .CSR_CYC(CSR), .CHR_CYC(CHR), .RAS_CYC(RASW), .PRE_CYC(PRE),
        .CAS_MASK(2'b11)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_gnt(bus_gnt), .bus_req(bus_req),
        .ras_n(ras_n), .lcas_n(lcas_n), .ucas_n(ucas_n), .ready(ready),
        .owed_cnt(owed_cnt), .err_sticky(err_sticky)
    );

    int n_checks = 0;
    int n_fail = 0;
    longint cyc = 0;
    int ras_falls = 0;
    bit gap_en = 0;
    bit have_prev = 0;
    longint prev_fall = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int exp_cycle_len();
        return RPC + CSR + RASW + PRE + 1;
    endfunction

    function automatic int exp_owed(input int k);
        return (k > OMAX) ? OMAX : k;
    endfunction

    function automatic int exp_rate(input int window);
        return window / INTERVAL;
    endfunction

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    endtask

    // strobe monitor, sampled at the falling clock edge
    logic p_ras, p_cas;
    int ras_lo_run, ras_hi_run, cas_lead_run, cas_in_ras, cas_hi_run;
    always @(negedge clk) begin
        if (!rst_n) begin
            p_ras = 1; p_cas = 1;
            ras_lo_run = 0; ras_hi_run = 1000; cas_lead_run = 0; cas_in_ras = 0; cas_hi_run = 1000;
        end else begin
            if (lcas_n !== ucas_n) check(0, "R4 lanes equal", lcas_n, ucas_n);
            if (p_ras && !ras_n) begin
                check(cas_lead_run == CSR, "R4 cas lead", cas_lead_run, CSR);
                check(ras_hi_run >= PRE, "R6 precharge", ras_hi_run, PRE);
                ras_falls++;
                if (gap_en && have_prev)
                    check((cyc - prev_fall) == exp_cycle_len(), "R9 spacing", cyc - prev_fall, exp_cycle_len());
                have_prev = 1;
                prev_fall = cyc;
            end
            if (!p_ras && ras_n) begin
                check(ras_lo_run == RASW, "R5 ras width", ras_lo_run, RASW);
                check(cas_in_ras == CHR, "R4 cas hold", cas_in_ras, CHR);
            end
            if (!ras_n && p_cas && !lcas_n) check(0, "R4 cas fall in ras", 1, 0);
            if (p_cas && !lcas_n) check(cas_hi_run >= RPC, "R6 cas precharge", cas_hi_run, RPC);
            ras_lo_run   = ras_n ? 0 : ras_lo_run + 1;
            ras_hi_run   = ras_n ? ras_hi_run + 1 : 0;
            cas_lead_run = (!lcas_n && ras_n) ? cas_lead_run + 1 : 0;
            cas_in_ras   = ras_n ? 0 : (!lcas_n ? cas_in_ras + 1 : cas_in_ras);
            cas_hi_run   = lcas_n ? cas_hi_run + 1 : 0;
            p_ras = ras_n;
            p_cas = lcas_n;
        end
    end

    // watchdog
    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int seed_v;
        int n;
        int f0;
        int k;
        int maxo;
        longint last_inc;
        logic [OW-1:0] prev_o;
        seed_v = $urandom(32'd4242);
        rst_n = 0;
        bus_gnt = 0;
        repeat (4) @(negedge clk);
        // R1 reset state
        check(ras_n && lcas_n && ucas_n, "R1 strobes idle", {ras_n, lcas_n, ucas_n}, 7);
        check(!bus_req && !ready, "R1 req/ready low", {bus_req, ready}, 0);
        check(owed_cnt == 0 && !err_sticky, "R1 owed/err clear", owed_cnt, 0);
        rst_n = 1;

        // R2 pause length
        n = 0;
        while (n < PAUSE + 50) begin
            @(posedge clk); n++;
            @(negedge clk);
            if (bus_req) break;
        end
        check(n == PAUSE, "R2 pause edges", n, PAUSE);
        check(ras_falls == 0, "R2 no strobe in pause", ras_falls, 0);

        // R3 wake burst, grant delayed at random
        f0 = ras_falls;
        repeat ($urandom_range(0, 20)) @(negedge clk);
        check(ras_falls == f0, "R8 no refresh without grant", ras_falls - f0, 0);
        bus_gnt = 1;
        n = 0;
        while (!ready && n < 1000) begin @(negedge clk); n++; end
        check(ras_falls - f0 == WAKE, "R3 wake cycles", ras_falls - f0, WAKE);
        check(ras_n && ready, "R3 ready after burst", {ras_n, ready}, 3);
        check(err_sticky == 0, "R11 err clear", err_sticky, 0);

        // R12 steady rate
        n = 0;
        while (owed_cnt != 1 && n < INTERVAL + 50) begin @(negedge clk); n++; end
        f0 = ras_falls;
        repeat (5 * INTERVAL - 1) @(negedge clk);
        check(ras_falls - f0 == exp_rate(5 * INTERVAL), "R12 one per interval",
              ras_falls - f0, exp_rate(5 * INTERVAL));

        // R7/R8/R9 random backlogs
        for (int r = 0; r < 4; r++) begin
            k = $urandom_range(2, 7);
            n = 0;
            while (bus_req && n < 100) begin @(negedge clk); n++; end
            bus_gnt = 0;
            f0 = ras_falls;
            last_inc = -1;
            prev_o = owed_cnt;
            n = 0;
            while (owed_cnt != OW'(k) && n < (k + 1) * INTERVAL + 50) begin
                @(negedge clk); n++;
                if (owed_cnt == prev_o + OW'(1)) begin
                    if (last_inc >= 0)
                        check(cyc - last_inc == INTERVAL, "R7 interval", cyc - last_inc, INTERVAL);
                    last_inc = cyc;
                end
                prev_o = owed_cnt;
            end
            check(owed_cnt == OW'(exp_owed(k)), "R7 owed count", owed_cnt, exp_owed(k));
            check(ras_falls == f0, "R8 withheld grant", ras_falls - f0, 0);
            have_prev = 0;
            gap_en = 1;
            bus_gnt = 1;
            repeat (300) @(negedge clk);
            gap_en = 0;
            check(ras_falls - f0 == k, "R9 backlog paid", ras_falls - f0, k);
            check(owed_cnt == 0, "R9 owed drained", owed_cnt, 0);
            check(!bus_req, "R8 request released", bus_req, 0);
        end

        // R10/R11 saturation
        n = 0;
        while (bus_req && n < 100) begin @(negedge clk); n++; end
        bus_gnt = 0;
        maxo = 0;
        n = 0;
        while (!err_sticky && n < (OMAX + 1) * INTERVAL + 50) begin
            @(negedge clk); n++;
            if (int'(owed_cnt) > maxo) maxo = int'(owed_cnt);
        end
        check(maxo == OMAX, "R10 owed ceiling", maxo, OMAX);
        check(!ready, "R10 ready dropped", ready, 0);
        check(owed_cnt == 0, "R10 owed cleared", owed_cnt, 0);
        f0 = ras_falls;
        repeat (30) @(negedge clk);
        check(bus_req && ras_falls == f0, "R10 burst waits grant", ras_falls - f0, 0);
        bus_gnt = 1;
        n = 0;
        while (!ready && n < 1000) begin @(negedge clk); n++; end
        check(ras_falls - f0 == WAKE, "R10 repeat burst", ras_falls - f0, WAKE);
        check(err_sticky == 1, "R11 err held", err_sticky, 1);
        repeat (2 * INTERVAL) @(negedge clk);
        check(err_sticky == 1 && ready, "R11 err sticky in run", {err_sticky, ready}, 3);

        // R1 reset clears the flag
        rst_n = 0;
        repeat (2) @(negedge clk);
        check(!err_sticky && !ready && !bus_req, "R1 reset clears", {err_sticky, ready, bus_req}, 0);
        finish_run();
    end

endmodule